// File: doc/BRIEF.md
# Interleaved Multi-Bank Burst Reader

This block serves multi-word read bursts from a word-addressed memory that is split into a power-of-two number of banks. Consecutive word addresses sit in consecutive banks: the low address bits pick the bank, and the remaining bits pick the row inside that bank. When a burst request is accepted, every bank that holds a word of the burst starts its read on the same clock edge. The memory latency is therefore paid once for the whole burst.

Each bank is modelled as a synchronous read memory with a fixed pipeline latency. Its contents are loaded from a fixed data pattern during reset. When a bank returns its word, the word is caught in a per-bank holding register. A sequencer then walks the banks in burst order, starting at the bank of the start address and wrapping past the last bank. It presents one word per cycle on a valid/ready output stream and flags the final word. A burst that crosses from the last bank to bank zero continues in the next row. A burst that crosses the top of the address space continues at address zero.

Only one burst is in flight at a time. The request side accepts a new burst only after the last word of the current burst has been taken by the consumer.

Top module: `ilv_burst_reader`

## Requirements
- R1: The bank index of a word is its address bits [BANK_BITS-1:0], and its row inside the bank is the remaining upper address bits.
- R2: `req_len` holds the number of words minus one (1 to NUM_BANKS words). The stream delivers exactly that many words. `out_last` is 1 on the final word and 0 on all the others, and no word follows the final one.
- R3: Word k of a burst that starts at address A carries the content of address (A+k) mod 2^ADDR_W. After reset, address a holds the low DATA_W bits of (a * 0x9E37) XOR 0x5A5A.
- R4: A burst that passes from the last bank to bank zero reads bank zero, and any later bank, at the row after the start row.
- R5: The first word of a burst appears on `out_valid` exactly LATENCY clock edges after the edge that accepts the request. Before then, `out_valid` is 0.
- R6: With `out_ready` held high, all words of a burst appear on consecutive cycles. Once the first word is valid, `out_valid` stays high until the final word is taken.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1, with `out_data` and `out_last` unchanged.
- R8: `req_ready` falls on the edge that accepts a request and stays low until the edge that transfers the final word, then returns to 1. A request held on `req_valid` while `req_ready` is 0 is not taken.
- R9: While `rst` is high and after it is released, `out_valid` is 0 and `req_ready` is 1. A burst cut off by reset produces no further words.
- R10: A burst that runs past address 2^ADDR_W-1 continues at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the first word |
| req_len | input | BANK_BITS | Burst length minus one |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final word of the burst |

## Verification
The hardest case to reach is a consumer stall while every holding register of a burst is full. In that case the sequencer must keep its pointer and all the held words while no new request can enter. The table of bursts includes stall masks that drop `out_ready` on chosen cycles of the output phase, including a burst that stalls on its first eight offers. On every stalled cycle the bench compares the word with the one seen the cycle before. `req_valid` is also held high with a different address for the whole of each burst. This shows that the request is not taken early and that a request right after the final word is taken cleanly. A reset in the middle of a burst checks that no word from the lost burst appears afterwards.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;

    // Fixed content pattern for the bank models, a function of the word address.
    function automatic logic [31:0] word_seed(input logic [31:0] addr);
        return (addr * 32'h0000_9E37) ^ 32'h0000_5A5A;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int DATA_W    = 16,
    parameter int ROW_W     = 6,
    parameter int BANK_BITS = 2,
    parameter int BANK_IDX  = 0,
    parameter int LATENCY   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    import ilv_pkg::*;

    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [LATENCY-1:0] vld_pipe;
    logic [DATA_W-1:0]  dat_pipe [LATENCY];

    // Contents are loaded from the pattern while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < DEPTH; r++) begin
                mem[r] <= DATA_W'(word_seed(32'((r << BANK_BITS) | BANK_IDX)));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_pipe <= '0;
        end else begin
            vld_pipe[0] <= rd_en;
            for (int s = 1; s < LATENCY; s++) begin
                vld_pipe[s] <= vld_pipe[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        dat_pipe[0] <= mem[rd_row];
        for (int s = 1; s < LATENCY; s++) begin
            dat_pipe[s] <= dat_pipe[s-1];
        end
    end

    assign rd_valid = vld_pipe[LATENCY-1];
    assign rd_data  = dat_pipe[LATENCY-1];

endmodule

// File: rtl/ilv_launch.sv
module ilv_launch #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_BITS = 2,
    parameter int ROW_W     = 6
) (
    input  logic                           fire,
    input  logic [BANK_BITS-1:0]           start_bank,
    input  logic [ROW_W-1:0]               start_row,
    input  logic [BANK_BITS-1:0]           len_m1,
    output logic [NUM_BANKS-1:0]           bank_en,
    output logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row
);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        localparam logic [BANK_BITS-1:0] IDX = BANK_BITS'(i);
        logic [BANK_BITS-1:0] offset;
        logic                 wrapped;

        // Position of this bank inside the burst, counted from the start bank.
        assign offset      = IDX - start_bank;
        assign wrapped     = IDX < start_bank;
        assign bank_en[i]  = fire && (offset <= len_m1);
        assign bank_row[i] = start_row + ROW_W'(wrapped);
    end

endmodule

// File: rtl/ilv_stream.sv
module ilv_stream #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_BITS = 2,
    parameter int DATA_W    = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             accept,
    input  logic [BANK_BITS-1:0]             start_bank,
    input  logic [BANK_BITS-1:0]             len_m1,
    input  logic [NUM_BANKS-1:0]             bank_vld,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data,
    input  logic                             out_ready,
    output logic                             out_valid,
    output logic [DATA_W-1:0]                out_data,
    output logic                             out_last,
    output logic                             idle
);
    import ilv_pkg::*;

    seq_state_e              state;
    logic [BANK_BITS-1:0]    cur;
    logic [BANK_BITS-1:0]    remain;
    logic [NUM_BANKS-1:0]    full;
    logic [DATA_W-1:0]       hold [NUM_BANKS];
    logic                    take;

    assign out_valid = (state == SEQ_SEND) && full[cur];
    assign out_data  = hold[cur];
    assign out_last  = (remain == '0);
    assign idle      = (state == SEQ_IDLE);
    assign take      = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            cur    <= '0;
            remain <= '0;
        end else if (accept) begin
            state  <= SEQ_SEND;
            cur    <= start_bank;
            remain <= len_m1;
        end else if (take) begin
            cur    <= cur + 1'b1;
            remain <= remain - 1'b1;
            if (remain == '0) begin
                state <= SEQ_IDLE;
            end
        end
    end

    // Fill flags: set when the bank returns its word, cleared when the word leaves.
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= '0;
        end else begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (bank_vld[i]) begin
                    full[i] <= 1'b1;
                end else if (take && (cur == BANK_BITS'(i))) begin
                    full[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_vld[i]) begin
                hold[i] <= bank_data[i];
            end
        end
    end

endmodule

// File: rtl/ilv_burst_reader.sv
module ilv_burst_reader #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int LATENCY   = 3,
    localparam int BANK_BITS = $clog2(NUM_BANKS),
    localparam int ROW_W     = ADDR_W - BANK_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [BANK_BITS-1:0]  req_len,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_last
);

    typedef struct packed {
        logic [ROW_W-1:0]     row;
        logic [BANK_BITS-1:0] bank;
    } word_addr_t;

    word_addr_t                       start;
    logic                             accept;
    logic                             idle;
    logic [NUM_BANKS-1:0]             bank_en;
    logic [NUM_BANKS-1:0][ROW_W-1:0]  bank_row;
    logic [NUM_BANKS-1:0]             bank_vld;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;

    assign start     = word_addr_t'(req_addr);
    assign req_ready = idle;
    assign accept    = req_valid && idle;

    ilv_launch #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BITS (BANK_BITS),
        .ROW_W     (ROW_W)
    ) u_launch (
        .fire       (accept),
        .start_bank (start.bank),
        .start_row  (start.row),
        .len_m1     (req_len),
        .bank_en    (bank_en),
        .bank_row   (bank_row)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_banks
        ilv_bank #(
            .DATA_W    (DATA_W),
            .ROW_W     (ROW_W),
            .BANK_BITS (BANK_BITS),
            .BANK_IDX  (b),
            .LATENCY   (LATENCY)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .rd_en    (bank_en[b]),
            .rd_row   (bank_row[b]),
            .rd_valid (bank_vld[b]),
            .rd_data  (bank_data[b])
        );
    end

    ilv_stream #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BITS (BANK_BITS),
        .DATA_W    (DATA_W)
    ) u_stream (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .start_bank (start.bank),
        .len_m1     (req_len),
        .bank_vld   (bank_vld),
        .bank_data  (bank_data),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .idle       (idle)
    );

endmodule

// File: rtl/ilv_burst_chk.sv
module ilv_burst_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last
);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R6
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid);

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> req_ready);

    // R8
    exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    // R5
    no_early_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !out_valid);

endmodule

bind ilv_burst_reader ilv_burst_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/ilv_burst_reader_test.sv
module ilv_burst_reader_test;

    localparam int NB  = 4;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int LAT = 3;

    typedef struct packed {
        logic [7:0] addr;
        logic [1:0] lenm1;
        logic [7:0] stall;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 2'd3, 8'h00},   // aligned, full length
        '{8'h06, 2'd2, 8'h00},   // wraps to bank 0 in next row
        '{8'h2D, 2'd0, 8'h00},   // single word
        '{8'hFE, 2'd3, 8'h00},   // crosses top of address space
        '{8'h0B, 2'd3, 8'h0A},   // scattered stalls
        '{8'h21, 2'd1, 8'h06},   // stalls before second word
        '{8'h37, 2'd3, 8'hFF}    // long stall on first offer
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_len = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic          out_last;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ilv_burst_reader #(
        .NUM_BANKS (NB),
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .LATENCY   (LAT)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
        logic [31:0] p;
        p = (32'(a) * 32'h9E37) ^ 32'h5A5A;
        return p[DW-1:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_burst(input logic [7:0] a, input logic [1:0] lm, input logic [7:0] stall);
        int            nwords;
        int            got;
        bit            prev_stall;
        logic [DW-1:0] prev_d;
        logic          prev_l;
        bit            rdy;
        logic [AW-1:0] ea;
        nwords     = int'(lm) + 1;
        got        = 0;
        prev_stall = 1'b0;
        prev_d     = '0;
        prev_l     = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = lm;
        out_ready = 1'b1;
        @(negedge clk);
        // Request stays asserted with other fields while busy (R8: not taken).
        req_addr  = ~a;
        req_len   = ~lm;
        for (int c = 0; c < 40 && got < nwords; c++) begin
            if (c > 0) @(negedge clk);
            chk(req_ready == 1'b0, "R8 busy", int'(req_ready), 0);
            if (c < LAT) begin
                chk(out_valid == 1'b0, "R5 no word before latency", int'(out_valid), 0);
            end else begin
                rdy = (c - LAT < 8) ? !stall[c-LAT] : 1'b1;
                out_ready = rdy;
                chk(out_valid == 1'b1, "R5 R6 word present", int'(out_valid), 1);
                if (prev_stall) begin
                    chk(out_data == prev_d, "R7 data held", int'(out_data), int'(prev_d));
                    chk(out_last == prev_l, "R7 last held", int'(out_last), int'(prev_l));
                end
                if (out_valid && rdy) begin
                    ea = a + AW'(got);
                    chk(out_data == expect_word(ea), "R1 R3 R4 R10 data",
                        int'(out_data), int'(expect_word(ea)));
                    chk(out_last == (got == nwords - 1), "R2 last flag",
                        int'(out_last), int'(got == nwords - 1));
                    got++;
                    if (got == nwords) req_valid = 1'b0;
                end
                prev_stall = out_valid && !rdy;
                prev_d     = out_data;
                prev_l     = out_last;
            end
        end
        chk(got == nwords, "R2 word count", got, nwords);
        req_valid = 1'b0;
        @(negedge clk);
        out_ready = 1'b1;
        chk(req_ready == 1'b1, "R8 released", int'(req_ready), 1);
        chk(out_valid == 1'b0, "R2 no extra word", int'(out_valid), 0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        chk(req_ready == 1'b1, "R9 reset req_ready", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 after reset out_valid", int'(out_valid), 0);
        chk(req_ready == 1'b1, "R9 after reset req_ready", int'(req_ready), 1);

        for (int v = 0; v < NVEC; v++) begin
            run_burst(VECS[v].addr, VECS[v].lenm1, VECS[v].stall);
        end

        // Reset in the middle of a burst: nothing from it may emerge afterwards.
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 8'h44;
        req_len   = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < LAT + 4; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 cut burst silent", int'(out_valid), 0);
            chk(req_ready == 1'b1, "R9 idle after reset", int'(req_ready), 1);
        end

        // Clean burst after the cut one, with a row wrap.
        run_burst(8'h7D, 2'd3, 8'h00);
        // Partial burst at the last bank only.
        run_burst(8'h93, 2'd0, 8'h01);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule